// File: doc/BRIEF.md
# Privilege-Filtered Retired-Instruction Counter

This block counts retired instructions for performance monitoring. Each cycle the core presents a retire pulse together with the context the instruction retired in: its privilege level (0 to 3), its security world (Secure, Non-secure or Realm) and whether it retired inside a transaction. A 64-bit counter advances by one for each retire pulse that the filter control register does not exclude. When the counter rolls over from all-ones to zero, a sticky overflow flag is set.

Most exclusions are not plain per-context enable bits. A base bit picks the default for a privilege level, and each world has a modifier bit that is compared with that base. Level 0, level 1 and level 3 contexts are dropped when their modifier *differs* from the base. Secure and Realm level 2 contexts are dropped when their modifier *equals* the level-2 base. The level-2 base itself has inverted polarity: 0 means exclude. A single software image can therefore express asymmetric policies across worlds.

Software reaches both registers through a simple write port and a combinational read port. Read-only and reserved filter bits are enforced on every write. The filter also stores an exception-mode bit, which has no effect on counting in this block.

Top module: `icnt_filtered_counter`

## Requirements
- R1: After reset the filter reads 0x0000_0000_0000_0008, the counter reads 0 and `ovf_flag` is 0.
- R2: Filter read data bits [15:0] are always 0x0008, and bits [63:59], [57:32], [25] and [19:16] always read 0. Writes to those bits are ignored. Bits 58, 31..26 and 24..20 hold the last value written, so writing all-ones reads back 0x0400_0000_FDF0_0008.
- R3: A retire pulse that no exclusion rule matches raises the counter by exactly one, visible on the cycle after the pulse. Cycles without a retire pulse leave the counter unchanged.
- R4: In the Secure world (world code 0), filter bit 31 set excludes level 1 and filter bit 30 set excludes level 0.
- R5: In the Non-secure world (world code 1), level 1 is excluded when bit 29 differs from bit 31, and level 0 is excluded when bit 28 differs from bit 30.
- R6: In the Realm world (world code 2), level 1 is excluded when bit 22 differs from bit 31, and level 0 is excluded when bit 21 differs from bit 30.
- R7: At level 2, the Non-secure world is excluded when bit 27 is 0, the Secure world is excluded when bit 24 equals bit 27, and the Realm world is excluded when bit 20 equals bit 27.
- R8: Level 3 is excluded in any world when bit 26 differs from bit 31.
- R9: With filter bit 23 set, a retire with `in_txn` low is not counted. A retire with `in_txn` high is unaffected by bit 23.
- R10: Filter bit 58 (1 selects synchronous exception mode, 0 asynchronous) is stored and read back, and has no effect on counting.
- R11: A write with `reg_sel` = 1 loads the counter from `reg_wdata`, and a read with `reg_sel` = 1 returns the counter. A counter write takes priority over a retire pulse in the same cycle.
- R12: An increment from all-ones wraps the counter to zero and sets `ovf_flag`. The flag then stays set until reset, even across counter writes.
- R13: World code 3 is reserved, and retires reported with it are never counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire | input | 1 | One instruction retired this cycle |
| priv_lvl | input | 2 | Privilege level of the retired instruction (0..3) |
| world | input | 2 | Security world: 0 Secure, 1 Non-secure, 2 Realm, 3 reserved |
| in_txn | input | 1 | Instruction retired inside a transaction |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 filter, 1 counter |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected register (combinational) |
| ovf_flag | output | 1 | Sticky counter overflow flag |

## Verification
Some properties are checked on every cycle against live traffic: the filter's constant low field, the one-step increment, the counter holding still when a retire is excluded at Non-secure level 2 or in the reserved world, wrap-around setting the flag, and the flag never clearing. The remaining behaviour can only be shown by the directed scenarios, which set up particular filter images. These cover the equal-versus-differ comparison for each world and level, the inverted level-2 base, the transaction suppression bit, the inert mode bit, and write-over-retire priority.

// File: rtl/icnt_pkg.sv
package icnt_pkg;

    localparam int REG_W = 64;

    // bit positions inside the filter image (software-visible layout)
    localparam int B_SYNC  = 58;
    localparam int B_K     = 31;
    localparam int B_U     = 30;
    localparam int B_NSK   = 29;
    localparam int B_NSU   = 28;
    localparam int B_H     = 27;
    localparam int B_M     = 26;
    localparam int B_SH    = 24;
    localparam int B_TXN   = 23;
    localparam int B_RLK   = 22;
    localparam int B_RLU   = 21;
    localparam int B_RLH   = 20;

    localparam logic [15:0]      EVT_CODE  = 16'h0008;
    localparam logic [REG_W-1:0] WR_MASK   = 64'h0400_0000_FDF0_0000;

    typedef enum logic [1:0] {
        WLD_SECURE = 2'd0,
        WLD_NONSEC = 2'd1,
        WLD_REALM  = 2'd2,
        WLD_RSVD   = 2'd3
    } icnt_world_e;

    typedef enum logic {
        SEL_FILTER  = 1'b0,
        SEL_COUNTER = 1'b1
    } icnt_sel_e;

    typedef struct packed {
        logic sync_mode;
        logic base_k;
        logic base_u;
        logic ns_k;
        logic ns_u;
        logic base_h;
        logic top_m;
        logic sec_h;
        logic txn_off;
        logic rl_k;
        logic rl_u;
        logic rl_h;
    } icnt_ctrl_t;

    typedef struct packed {
        logic [1:0]  priv;
        icnt_world_e world;
        logic        txn;
    } icnt_ctx_t;

    function automatic icnt_ctrl_t unpack_ctrl(input logic [REG_W-1:0] img);
        icnt_ctrl_t c;
        c.sync_mode = img[B_SYNC];
        c.base_k    = img[B_K];
        c.base_u    = img[B_U];
        c.ns_k      = img[B_NSK];
        c.ns_u      = img[B_NSU];
        c.base_h    = img[B_H];
        c.top_m     = img[B_M];
        c.sec_h     = img[B_SH];
        c.txn_off   = img[B_TXN];
        c.rl_k      = img[B_RLK];
        c.rl_u      = img[B_RLU];
        c.rl_h      = img[B_RLH];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input icnt_ctrl_t c);
        logic [REG_W-1:0] img;
        img          = '0;
        img[15:0]    = EVT_CODE;
        img[B_SYNC]  = c.sync_mode;
        img[B_K]     = c.base_k;
        img[B_U]     = c.base_u;
        img[B_NSK]   = c.ns_k;
        img[B_NSU]   = c.ns_u;
        img[B_H]     = c.base_h;
        img[B_M]     = c.top_m;
        img[B_SH]    = c.sec_h;
        img[B_TXN]   = c.txn_off;
        img[B_RLK]   = c.rl_k;
        img[B_RLU]   = c.rl_u;
        img[B_RLH]   = c.rl_h;
        return img;
    endfunction

    // level-0/1 rule: Secure uses the base bit directly; the other worlds
    // compare their modifier with the base
    function automatic logic low_level_drop(input logic base, input logic ns_mod,
                                            input logic rl_mod, input icnt_world_e w);
        logic d;
        case (w)
            WLD_SECURE: d = base;
            WLD_NONSEC: d = (ns_mod != base);
            WLD_REALM:  d = (rl_mod != base);
            default:    d = 1'b1;
        endcase
        return d;
    endfunction

    function automatic logic hyp_level_drop(input icnt_ctrl_t c, input icnt_world_e w);
        logic d;
        case (w)
            WLD_NONSEC: d = ~c.base_h;
            WLD_SECURE: d = (c.sec_h == c.base_h);
            WLD_REALM:  d = (c.rl_h == c.base_h);
            default:    d = 1'b1;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/icnt_filter_reg.sv
module icnt_filter_reg
    import icnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output icnt_ctrl_t       ctrl,
    output logic [REG_W-1:0] rd_img
);

    icnt_ctrl_t       ctrl_q;
    logic [REG_W-1:0] wr_masked;

    assign wr_masked = wdata & WR_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= unpack_ctrl(wr_masked);
        end
    end

    assign ctrl   = ctrl_q;
    assign rd_img = pack_ctrl(ctrl_q);

    AST_FILTER_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_img & ~WR_MASK) == {48'h0, EVT_CODE}) else $error("reserved bits"); // R2

    AST_FILTER_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_img & WR_MASK) == ($past(wdata) & WR_MASK)) else $error("write"); // R2

endmodule

// File: rtl/icnt_ctx_gate.sv
module icnt_ctx_gate
    import icnt_pkg::*;
(
    input  icnt_ctrl_t ctrl,
    input  icnt_ctx_t  ctx,
    input  logic       retire,
    output logic       count_ok
);

    logic drop_lvl;
    logic drop_txn;

    always_comb begin
        case (ctx.priv)
            2'd0:    drop_lvl = low_level_drop(ctrl.base_u, ctrl.ns_u, ctrl.rl_u, ctx.world);
            2'd1:    drop_lvl = low_level_drop(ctrl.base_k, ctrl.ns_k, ctrl.rl_k, ctx.world);
            2'd2:    drop_lvl = hyp_level_drop(ctrl, ctx.world);
            default: drop_lvl = (ctrl.top_m != ctrl.base_k) || (ctx.world == WLD_RSVD);
        endcase
        drop_txn = ctrl.txn_off & ~ctx.txn;
    end

    assign count_ok = retire & ~drop_lvl & ~drop_txn;

endmodule

// File: rtl/icnt_counter.sv
module icnt_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             wrap;

    assign wrap = inc & ~load & (cnt_q == ALL_ONES);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (load) begin
                cnt_q <= load_val;
            end else if (inc) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (wrap) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign count = cnt_q;
    assign ovf   = ovf_q;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && count != ALL_ONES) |=> count == $past(count) + 1'b1) else $error("step"); // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!inc && !load) |=> $stable(count)) else $error("idle"); // R3

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load |=> count == $past(load_val)) else $error("load"); // R11

    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && count == ALL_ONES) |=> (count == '0 && ovf)) else $error("wrap"); // R12

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf) else $error("sticky"); // R12

endmodule

// File: rtl/icnt_filtered_counter.sv
module icnt_filtered_counter
    import icnt_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        retire,
    input  logic [1:0]  priv_lvl,
    input  logic [1:0]  world,
    input  logic        in_txn,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    output logic        ovf_flag
);

    localparam int PAD_W = REG_W - CNT_W;

    icnt_ctrl_t       ctrl;
    icnt_ctx_t        ctx;
    logic [REG_W-1:0] filt_img;
    logic [CNT_W-1:0] count;
    logic             count_ok;
    logic             wr_filt;
    logic             wr_cnt;

    assign wr_filt   = reg_wr & (reg_sel == SEL_FILTER);
    assign wr_cnt    = reg_wr & (reg_sel == SEL_COUNTER);
    assign ctx.priv  = priv_lvl;
    assign ctx.world = icnt_world_e'(world);
    assign ctx.txn   = in_txn;

    icnt_filter_reg u_filt (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_filt),
        .wdata  (reg_wdata),
        .ctrl   (ctrl),
        .rd_img (filt_img)
    );

    icnt_ctx_gate u_gate (
        .ctrl     (ctrl),
        .ctx      (ctx),
        .retire   (retire),
        .count_ok (count_ok)
    );

    icnt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .inc      (count_ok),
        .load     (wr_cnt),
        .load_val (reg_wdata[CNT_W-1:0]),
        .count    (count),
        .ovf      (ovf_flag)
    );

    generate
        if (PAD_W > 0) begin : g_pad
            assign reg_rdata = (reg_sel == SEL_COUNTER) ? {{PAD_W{1'b0}}, count} : filt_img;
        end else begin : g_nopad
            assign reg_rdata = (reg_sel == SEL_COUNTER) ? count : filt_img;
        end
    endgenerate

    AST_EVT_FIELD: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 1'b0) |-> reg_rdata[15:0] == 16'h0008) else $error("evt"); // R2

    AST_NS_HYP_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (retire && priv_lvl == 2'd2 && world == 2'd1 && !reg_rdata[27] && reg_sel == 1'b0 && !reg_wr)
        |=> $stable(count)) else $error("ns lvl2"); // R7

    AST_RSVD_WORLD_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (world == 2'd3 && !reg_wr) |=> $stable(count)) else $error("rsvd world"); // R13

endmodule

// File: tb/icnt_filtered_counter_bench.sv
module icnt_filtered_counter_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        retire;
    logic [1:0]  priv_lvl;
    logic [1:0]  world;
    logic        in_txn;
    logic        reg_wr;
    logic        reg_sel;
    logic [63:0] reg_wdata;
    logic [63:0] reg_rdata;
    logic        ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    icnt_filtered_counter u_icnt_filtered_counter (
        .clk(clk), .rst(rst), .retire(retire), .priv_lvl(priv_lvl), .world(world),
        .in_txn(in_txn), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ovf_flag(ovf_flag)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_reg(input logic sel, output logic [63:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [1:0] p, input logic [1:0] w, input logic t, input int n);
        @(negedge clk);
        priv_lvl = p; world = w; in_txn = t;
        for (int i = 0; i < n; i++) begin
            retire = 1'b1;
            @(negedge clk);
        end
        retire = 1'b0;
    endtask

    task automatic expect_delta(input string req, input logic [1:0] p, input logic [1:0] w,
                                input logic t, input int n, input int exp);
        logic [63:0] c0, c1;
        rd_reg(1'b1, c0);
        pulse(p, w, t, n);
        rd_reg(1'b1, c1);
        check(req, c1 - c0, 64'(exp));
    endtask

    task automatic t_reset;
        logic [63:0] d;
        rd_reg(1'b0, d); check("R1 filter", d, 64'h8);
        rd_reg(1'b1, d); check("R1 counter", d, 64'h0);
        check("R1 flag", {63'h0, ovf_flag}, 64'h0);
    endtask

    task automatic t_filter_rw;
        logic [63:0] d;
        wr_reg(1'b0, '1);
        rd_reg(1'b0, d); check("R2 all-ones image", d, 64'h0400_0000_FDF0_0008);
        wr_reg(1'b0, 64'hFBFF_FFFF_020F_FFF7);
        rd_reg(1'b0, d); check("R2 reserved-only write", d, 64'h8);
        wr_reg(1'b0, 64'h0400_0000_0000_0000);
        rd_reg(1'b0, d); check("R10 mode bit stored", d, 64'h0400_0000_0000_0008);
        wr_reg(1'b0, 64'h0);
    endtask

    task automatic t_basic;
        expect_delta("R3 secure lvl0 x5", 2'd0, 2'd0, 1'b0, 5, 5);
        expect_delta("R3 ns lvl1 x3", 2'd1, 2'd1, 1'b0, 3, 3);
        expect_delta("R3 no retire", 2'd0, 2'd0, 1'b0, 0, 0);
    endtask

    task automatic t_secure_low;
        wr_reg(1'b0, 64'h8000_0000);
        expect_delta("R4 secure lvl1 excluded", 2'd1, 2'd0, 1'b0, 2, 0);
        expect_delta("R4 secure lvl0 counted", 2'd0, 2'd0, 1'b0, 2, 2);
        wr_reg(1'b0, 64'h4000_0000);
        expect_delta("R4 secure lvl0 excluded", 2'd0, 2'd0, 1'b0, 2, 0);
    endtask

    task automatic t_nonsecure;
        wr_reg(1'b0, 64'h2000_0000);
        expect_delta("R5 ns lvl1 29!=31", 2'd1, 2'd1, 1'b0, 2, 0);
        wr_reg(1'b0, 64'hA000_0000);
        expect_delta("R5 ns lvl1 29==31", 2'd1, 2'd1, 1'b0, 2, 2);
        expect_delta("R5 secure lvl1 still off", 2'd1, 2'd0, 1'b0, 1, 0);
        wr_reg(1'b0, 64'h4000_0000);
        expect_delta("R5 ns lvl0 28!=30", 2'd0, 2'd1, 1'b0, 2, 0);
        wr_reg(1'b0, 64'h5000_0000);
        expect_delta("R5 ns lvl0 28==30", 2'd0, 2'd1, 1'b0, 2, 2);
    endtask

    task automatic t_realm;
        wr_reg(1'b0, 64'h0040_0000);
        expect_delta("R6 realm lvl1 22!=31", 2'd1, 2'd2, 1'b0, 2, 0);
        expect_delta("R6 ns lvl1 unaffected", 2'd1, 2'd1, 1'b0, 1, 1);
        wr_reg(1'b0, 64'h4020_0000);
        expect_delta("R6 realm lvl0 21==30", 2'd0, 2'd2, 1'b0, 2, 2);
        wr_reg(1'b0, 64'h4000_0000);
        expect_delta("R6 realm lvl0 21!=30", 2'd0, 2'd2, 1'b0, 2, 0);
    endtask

    task automatic t_hyp;
        wr_reg(1'b0, 64'h0);
        expect_delta("R7 ns lvl2 bit27=0", 2'd2, 2'd1, 1'b0, 2, 0);
        expect_delta("R7 secure lvl2 24==27", 2'd2, 2'd0, 1'b0, 2, 0);
        expect_delta("R7 realm lvl2 20==27", 2'd2, 2'd2, 1'b0, 2, 0);
        wr_reg(1'b0, 64'h0800_0000);
        expect_delta("R7 ns lvl2 bit27=1", 2'd2, 2'd1, 1'b0, 2, 2);
        expect_delta("R7 secure lvl2 24!=27", 2'd2, 2'd0, 1'b0, 2, 2);
        expect_delta("R7 realm lvl2 20!=27", 2'd2, 2'd2, 1'b0, 2, 2);
        wr_reg(1'b0, 64'h0910_0000);
        expect_delta("R7 secure lvl2 both set", 2'd2, 2'd0, 1'b0, 1, 0);
        expect_delta("R7 realm lvl2 both set", 2'd2, 2'd2, 1'b0, 1, 0);
        wr_reg(1'b0, 64'h0100_0000);
        expect_delta("R7 secure lvl2 24=1 27=0", 2'd2, 2'd0, 1'b0, 1, 1);
    endtask

    task automatic t_top;
        wr_reg(1'b0, 64'h0);
        expect_delta("R8 lvl3 26==31", 2'd3, 2'd0, 1'b0, 2, 2);
        wr_reg(1'b0, 64'h0400_0000);
        expect_delta("R8 lvl3 26!=31", 2'd3, 2'd0, 1'b0, 2, 0);
        wr_reg(1'b0, 64'h8400_0000);
        expect_delta("R8 lvl3 both set", 2'd3, 2'd1, 1'b0, 2, 2);
    endtask

    task automatic t_txn;
        wr_reg(1'b0, 64'h0080_0000);
        expect_delta("R9 non-txn suppressed", 2'd0, 2'd0, 1'b0, 2, 0);
        expect_delta("R9 txn counted", 2'd0, 2'd0, 1'b1, 2, 2);
        wr_reg(1'b0, 64'h0);
        expect_delta("R9 bit clear non-txn", 2'd0, 2'd0, 1'b0, 1, 1);
    endtask

    task automatic t_mode_bit;
        wr_reg(1'b0, 64'h0400_0000_0000_0000);
        expect_delta("R10 mode bit inert", 2'd0, 2'd1, 1'b0, 3, 3);
        wr_reg(1'b0, 64'h0);
    endtask

    task automatic t_rsvd_world;
        expect_delta("R13 world 3 lvl0", 2'd0, 2'd3, 1'b0, 2, 0);
        expect_delta("R13 world 3 lvl3", 2'd3, 2'd3, 1'b1, 2, 0);
    endtask

    task automatic t_cnt_write;
        logic [63:0] d;
        wr_reg(1'b1, 64'd100);
        rd_reg(1'b1, d); check("R11 load readback", d, 64'd100);
        @(negedge clk);
        priv_lvl = 2'd0; world = 2'd0; in_txn = 1'b0; retire = 1'b1;
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 64'd200;
        @(negedge clk);
        retire = 1'b0; reg_wr = 1'b0;
        rd_reg(1'b1, d); check("R11 write beats retire", d, 64'd200);
    endtask

    task automatic t_wrap;
        logic [63:0] d;
        wr_reg(1'b1, 64'hFFFF_FFFF_FFFF_FFFE);
        pulse(2'd0, 2'd0, 1'b0, 1);
        check("R12 no flag before wrap", {63'h0, ovf_flag}, 64'h0);
        pulse(2'd0, 2'd0, 1'b0, 1);
        rd_reg(1'b1, d); check("R12 wrapped to zero", d, 64'h0);
        check("R12 flag set", {63'h0, ovf_flag}, 64'h1);
        wr_reg(1'b1, 64'd5);
        @(negedge clk);
        check("R12 flag sticky", {63'h0, ovf_flag}, 64'h1);
    endtask

    initial begin
        rst = 1'b1; retire = 1'b0; priv_lvl = '0; world = '0; in_txn = 1'b0;
        reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_filter_rw();
        t_basic();
        t_secure_low();
        t_nonsecure();
        t_realm();
        t_hyp();
        t_top();
        t_txn();
        t_mode_bit();
        t_rsvd_world();
        t_cnt_write();
        t_wrap();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule